// File: doc/BRIEF.md
# Programming Command Test Data Register

This block is a 15-bit test data register placed behind a boundary-scan TAP controller. It carries commands from the scan port to a memory-programming engine, and it carries each command's result back out. The TAP controller supplies one-hot state decodes for Capture-DR, Shift-DR, Update-DR and Run-Test/Idle. The instruction decoder supplies a select line that is high while this register's instruction is active. Every state change happens on the rising edge of TCK.

A host uses it in a fixed loop. Capture-DR loads the engine's result bus into the scan register. Shift-DR then moves that result out on TDO while the next command moves in from TDI. Update-DR applies the new command to the engine's parallel inputs with a one-cycle valid strobe. Entering Run-Test/Idle produces a single execute pulse for the applied command. While the select line is low, the register ignores every TAP state.

Top module: `cmdreg_tdr`

## Requirements
- R1: While trst_n is low, cmd_o, cmd_valid_o, exec_o and the scan register are all zero, so tdo reads 0.
- R2: A TCK edge with sel and cap_st high loads result_i into the scan register. After that edge, tdo shows result_i[0].
- R3: Each TCK edge with sel and shift_st high shifts the scan register toward bit 0. TDI enters at bit 14 and tdo is bit 0. Fifteen such edges after a capture bring out the captured result least significant bit first, and leave the 15 shifted-in bits (first bit at position 0) in the register.
- R4: A TCK edge with sel and upd_st high copies the scan register to cmd_o. cmd_valid_o is high during exactly the following cycle.
- R5: cmd_o changes only at an update edge. Capture, shift and idle edges leave it unchanged.
- R6: When sel and idle_st are first seen high together, exec_o is high for the following cycle only. It stays low on later idle edges of the same stay in Run-Test/Idle.
- R7: With sel low, the capture, shift, update and idle decodes have no effect on the scan register, cmd_o, cmd_valid_o or exec_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sel | input | 1 | This register's instruction is active |
| cap_st | input | 1 | TAP is in Capture-DR |
| shift_st | input | 1 | TAP is in Shift-DR |
| upd_st | input | 1 | TAP is in Update-DR |
| idle_st | input | 1 | TAP is in Run-Test/Idle |
| tdi | input | 1 | Serial scan input |
| result_i | input | 15 | Result of the previous command from the programming engine |
| tdo | output | 1 | Serial scan output (bit 0 of the scan register) |
| cmd_o | output | 15 | Applied command to the programming engine |
| cmd_valid_o | output | 1 | One-cycle strobe after a new command is applied |
| exec_o | output | 1 | One-cycle execute pulse on entry to Run-Test/Idle |

## Verification
Each result has one register between the qualifying TCK edge and the port, so it is due in the cycle after that edge. tdo follows a capture or shift edge at once. cmd_o and cmd_valid_o follow an update edge at once. exec_o follows the first idle edge of an entry. The bench changes inputs right after a falling edge and samples at the next falling edge, so every check looks at exactly one edge's effect. Across a sweep of commands, it also checks that cmd_valid_o and exec_o fall back low on the following edge.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
  parameter int unsigned CMD_W = 15;
  localparam int unsigned MSB  = CMD_W - 1;
  typedef logic [CMD_W-1:0] cmd_t;
endpackage

// File: rtl/cmdreg_shift.sv
module cmdreg_shift
  import cmdreg_pkg::*;
(
  input  logic tck,
  input  logic trst_n,
  input  logic cap_en,
  input  logic shift_en,
  input  logic tdi,
  input  cmd_t par_i,
  output cmd_t sr_o
);
  cmd_t sr_q, sr_d;
  logic sr_en;

  assign sr_en = cap_en | shift_en;

  always_comb begin
    sr_d = sr_q;
    if (cap_en)        sr_d = par_i;
    else if (shift_en) sr_d = {tdi, sr_q[MSB:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)    sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/cmdreg_hold.sv
module cmdreg_hold
  import cmdreg_pkg::*;
(
  input  logic tck,
  input  logic trst_n,
  input  logic upd_en,
  input  cmd_t sr_i,
  output cmd_t cmd_o,
  output logic valid_o
);
  cmd_t cmd_q;
  logic vld_q, vld_d;

  assign vld_d = upd_en;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     cmd_q <= '0;
    else if (upd_en) cmd_q <= sr_i;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) vld_q <= 1'b0;
    else         vld_q <= vld_d;
  end

  assign cmd_o   = cmd_q;
  assign valid_o = vld_q;
endmodule

// File: rtl/cmdreg_strobe.sv
module cmdreg_strobe (
  input  logic tck,
  input  logic trst_n,
  input  logic idle_en,
  output logic pulse_o
);
  logic seen_q, seen_d;
  logic pls_q, pls_d;

  always_comb begin
    seen_d = idle_en;
    pls_d  = idle_en & ~seen_q;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      seen_q <= 1'b0;
      pls_q  <= 1'b0;
    end else begin
      seen_q <= seen_d;
      pls_q  <= pls_d;
    end
  end

  assign pulse_o = pls_q;
endmodule

// File: rtl/cmdreg_tdr.sv
module cmdreg_tdr
  import cmdreg_pkg::*;
(
  input  logic             tck,
  input  logic             trst_n,
  input  logic             sel,
  input  logic             cap_st,
  input  logic             shift_st,
  input  logic             upd_st,
  input  logic             idle_st,
  input  logic             tdi,
  input  logic [CMD_W-1:0] result_i,
  output logic             tdo,
  output logic [CMD_W-1:0] cmd_o,
  output logic             cmd_valid_o,
  output logic             exec_o
);
  cmd_t sr;
  logic cap_en, shift_en, upd_en, idle_en;

  assign cap_en   = sel & cap_st;
  assign shift_en = sel & shift_st & ~cap_st;
  assign upd_en   = sel & upd_st;
  assign idle_en  = sel & idle_st;

  cmdreg_shift u_shift (
    .tck(tck), .trst_n(trst_n), .cap_en(cap_en), .shift_en(shift_en),
    .tdi(tdi), .par_i(result_i), .sr_o(sr)
  );

  cmdreg_hold u_hold (
    .tck(tck), .trst_n(trst_n), .upd_en(upd_en), .sr_i(sr),
    .cmd_o(cmd_o), .valid_o(cmd_valid_o)
  );

  cmdreg_strobe u_strobe (
    .tck(tck), .trst_n(trst_n), .idle_en(idle_en), .pulse_o(exec_o)
  );

  assign tdo = sr[0];
endmodule

// File: rtl/cmdreg_tdr_chk.sv
module cmdreg_tdr_chk
  import cmdreg_pkg::*;
(
  input logic             tck,
  input logic             trst_n,
  input logic             sel,
  input logic             cap_st,
  input logic             shift_st,
  input logic             upd_st,
  input logic             idle_st,
  input logic [CMD_W-1:0] result_i,
  input logic             tdo,
  input logic [CMD_W-1:0] cmd_o,
  input logic             cmd_valid_o,
  input logic             exec_o
);
  always_comb begin
    if (!trst_n) begin
      AST_RESET_QUIET: assert (!exec_o && !cmd_valid_o && cmd_o == '0 && !tdo); // R1
    end
  end

  AST_CAPTURE_LSB: assert property (@(posedge tck) disable iff (!trst_n)
    (sel && cap_st) |=> (tdo == $past(result_i[0]))); // R2

  AST_VALID_AFTER_UPD: assert property (@(posedge tck) disable iff (!trst_n)
    (sel && upd_st) |=> cmd_valid_o); // R4

  AST_VALID_ONE: assert property (@(posedge tck) disable iff (!trst_n)
    !(sel && upd_st) |=> !cmd_valid_o); // R4

  AST_CMD_HELD: assert property (@(posedge tck) disable iff (!trst_n)
    !(sel && upd_st) |=> $stable(cmd_o)); // R5

  AST_EXEC_SINGLE: assert property (@(posedge tck) disable iff (!trst_n)
    exec_o |=> !exec_o); // R6

  AST_EXEC_NEEDS_IDLE: assert property (@(posedge tck) disable iff (!trst_n)
    !(sel && idle_st) |=> !exec_o); // R6

  AST_DESEL_NO_STROBE: assert property (@(posedge tck) disable iff (!trst_n)
    !sel |=> (!exec_o && !cmd_valid_o)); // R7

  AST_DESEL_TDO_HELD: assert property (@(posedge tck) disable iff (!trst_n)
    !sel |=> $stable(tdo)); // R7
endmodule

bind cmdreg_tdr cmdreg_tdr_chk u_chk (
  .tck(tck), .trst_n(trst_n), .sel(sel), .cap_st(cap_st), .shift_st(shift_st),
  .upd_st(upd_st), .idle_st(idle_st), .result_i(result_i), .tdo(tdo),
  .cmd_o(cmd_o), .cmd_valid_o(cmd_valid_o), .exec_o(exec_o)
);

// File: tb/cmdreg_tdr_bench.sv
`timescale 1ns/1ps
module cmdreg_tdr_bench;
  localparam int W = 15;

  logic tck = 1'b0;
  logic trst_n, sel, cap_st, shift_st, upd_st, idle_st, tdi;
  logic [W-1:0] result_i;
  logic tdo, cmd_valid_o, exec_o;
  logic [W-1:0] cmd_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 tck = ~tck;

  cmdreg_tdr u_cmdreg_tdr (
    .tck(tck), .trst_n(trst_n), .sel(sel), .cap_st(cap_st), .shift_st(shift_st),
    .upd_st(upd_st), .idle_st(idle_st), .tdi(tdi), .result_i(result_i),
    .tdo(tdo), .cmd_o(cmd_o), .cmd_valid_o(cmd_valid_o), .exec_o(exec_o)
  );

  function automatic logic [W-1:0] engine(input logic [W-1:0] c);
    return ((c * 15'd13) ^ 15'h2A5A) & 15'h7FFF;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic s, input logic c, input logic sh, input logic u, input logic i, input logic d);
    sel = s; cap_st = c; shift_st = sh; upd_st = u; idle_st = i; tdi = d;
  endtask

  task automatic tick();
    @(negedge tck);
  endtask

  task automatic run_cmd(input logic [W-1:0] c, input logic [W-1:0] prev_cmd);
    logic [W-1:0] r;
    r = engine(prev_cmd);
    result_i = r;
    drive(1, 1, 0, 0, 0, 0); tick();
    chk("R2 capture lsb", {14'd0, tdo}, {14'd0, r[0]});
    for (int k = 0; k < W; k++) begin
      chk("R3 shift-out bit", {14'd0, tdo}, {14'd0, r[k]});
      drive(1, 0, 1, 0, 0, c[k]); tick();
      chk("R5 cmd held in shift", cmd_o, prev_cmd);
    end
    drive(1, 0, 0, 1, 0, 0); tick();
    chk("R4 cmd applied", cmd_o, c);
    chk("R4 valid high", {14'd0, cmd_valid_o}, 15'd1);
    chk("R6 no exec yet", {14'd0, exec_o}, 15'd0);
    drive(1, 0, 0, 0, 1, 0); tick();
    chk("R4 valid one cycle", {14'd0, cmd_valid_o}, 15'd0);
    chk("R6 exec pulse", {14'd0, exec_o}, 15'd1);
    tick();
    chk("R6 exec once", {14'd0, exec_o}, 15'd0);
    tick();
    chk("R6 exec still low", {14'd0, exec_o}, 15'd0);
    chk("R5 cmd held in idle", cmd_o, c);
  endtask

  initial begin
    logic [W-1:0] prev, c, r;
    trst_n = 0; result_i = 15'h5555;
    drive(1, 1, 0, 1, 1, 1);
    repeat (3) tick();
    chk("R1 cmd reset", cmd_o, 15'd0);
    chk("R1 valid reset", {14'd0, cmd_valid_o}, 15'd0);
    chk("R1 exec reset", {14'd0, exec_o}, 15'd0);
    chk("R1 tdo reset", {14'd0, tdo}, 15'd0);
    drive(0, 0, 0, 0, 0, 0);
    tick(); trst_n = 1; tick();

    prev = '0;
    for (int n = 0; n < 300; n++) begin
      if (n == 0) c = 15'h0000;
      else if (n == 1) c = 15'h7FFF;
      else c = (n * 109 + 7) & 15'h7FFF;
      run_cmd(c, prev);
      prev = c;
    end

    // R7: capture while selected, then deselected activity must not disturb anything
    r = engine(prev);
    result_i = r;
    drive(1, 1, 0, 0, 0, 0); tick();
    result_i = ~r;
    drive(0, 1, 0, 0, 0, 1); tick();
    drive(0, 0, 1, 0, 0, 1); repeat (5) tick();
    chk("R7 tdo unchanged deselected", {14'd0, tdo}, {14'd0, r[0]});
    drive(0, 0, 0, 1, 0, 0); tick();
    chk("R7 no update deselected", cmd_o, prev);
    chk("R7 no valid deselected", {14'd0, cmd_valid_o}, 15'd0);
    drive(0, 0, 0, 0, 1, 0); tick();
    chk("R7 no exec deselected", {14'd0, exec_o}, 15'd0);
    for (int k = 0; k < W; k++) begin
      chk("R7 captured value intact", {14'd0, tdo}, {14'd0, r[k]});
      drive(1, 0, 1, 0, 0, 0); tick();
    end
    drive(0, 0, 0, 0, 0, 0); tick();
    done = 1;
  end

  initial begin
    for (int t = 0; t < 150000; t++) begin
      if (done) break;
      @(posedge tck);
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule